// File: doc/BRIEF.md
# Pixel Test Pattern Generator

This block stands in for a sensor's readout path. It produces a synthetic 14-bit pixel word on every clock so that a downstream serial link and its receiver can be checked against known data. The block is configured through plain input fields: pattern mode, start-period length, valid-region width, a 14-bit base value, a pitch and a step. It runs only while both the global test enable and the pattern enable are high.

A line begins at a rising edge of `line_start`. Each line has two parts. It opens with a start period, during which the output is zero. A valid region follows, where the selected pattern is drawn. After the valid region the output goes back to zero until the next line edge.

Two modes ignore this framing and send a constant word instead. One of them waits for the first line edge before it starts. The other starts as soon as the block is armed.

Top module: `pix_testgen`

## Requirements
- R1: While `test_en` or `pat_en` is low, `pix_out` is 0 one clock later. The pixel and line counters are cleared, so the first line edge after re-arming is line index 0 and pixel 0.
- R2: A rising edge of `line_start` sampled at clock k puts pixel p of the new line on `pix_out` after clock k+1+p. In modes 0 to 4, pixels p < `start_len` read 0. Pixels from `start_len` to `start_len`+`valid_w`-1 form the valid region, with valid index h = p-`start_len`. Later pixels read 0. A new edge restarts the line even in mid-line.
- R3: Mode code 0 draws the base value V = {`val_hi`,`val_lo`} on every valid pixel.
- R4: Mode code 1 is a horizontal ramp with P = `pitch`, where a pitch of 0 counts as 1. Valid pixel h shows level n = h/P (integer division). Level 0 is V. Each later level adds `step`. If the sum would exceed 0x3FFF, the level reloads V instead.
- R5: Mode code 2 uses the same ramp, but with n = L/P, where L is the line index: 0 for the first line after arming, then rising by 1 per edge. The level is constant across a line's valid region.
- R6: Mode code 3 draws a lattice. A valid pixel shows `step` when h mod P = 0 or L mod P = 0. Otherwise it shows V.
- R7: Mode code 4 draws vertical stripes. A valid pixel shows `step` when h/P is even and V when it is odd.
- R8: Mode code 5 outputs 0 until the first line edge after arming. From the clock after that edge, it outputs V on every pixel, including the start period and the pixels past the valid region.
- R9: Mode code 6 outputs V from the clock after arming, with no line edge needed.
- R10: Mode code 7 outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous active-high reset |
| test_en | input | 1 | global test-mode enable |
| pat_en | input | 1 | pattern enable |
| line_start | input | 1 | line strobe; its rising edge starts a line |
| mode | input | 3 | pattern mode code 0 to 7 |
| start_len | input | CW | start-period length in pixels |
| valid_w | input | CW | valid-region width in pixels |
| val_hi | input | 6 | upper 6 bits of the base value |
| val_lo | input | 8 | lower 8 bits of the base value |
| pitch | input | CW | level/band/grid spacing (0 acts as 1) |
| step | input | 14 | ramp increment, or dark level for lattice and stripes |
| pix_out | output | 14 | registered pixel word |

## Verification
Three pairs of events can land on the same clock.

- **Line edge during a valid region.** A new line edge can arrive while the previous line's valid region is still being drawn. The bench provokes this by sending strobes closer together than the start period plus the width. It expects the restart to win: the horizontal ramp, stripe phase and pixel index restart, and the vertical index advances.
- **Disarm on a line edge.** Pattern enable can drop on the same clock as a line edge. The disarm must take priority, and the line index after re-arming must start again at 0.
- **Ramp wrap on a level change.** In the ramp modes, a level change and a full-scale wrap fall on the same pixel. The reference model decides the reload value independently from the step and base.

// File: rtl/pixtg_pkg.sv
package pixtg_pkg;
  localparam int DW = 14;

  typedef enum logic [2:0] {
    PM_FIXED     = 3'd0,
    PM_HRAMP     = 3'd1,
    PM_VRAMP     = 3'd2,
    PM_GRID      = 3'd3,
    PM_STRIPE    = 3'd4,
    PM_WORD_SYNC = 3'd5,
    PM_WORD_FREE = 3'd6
  } pm_e;

  // Advance a ramp level by one increment, reloading the base past full scale.
  function automatic logic [DW-1:0] ramp_next(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] inc,
                                               input logic [DW-1:0] base);
    logic [DW:0] sum;
    sum = {1'b0, cur} + {1'b0, inc};
    return sum[DW] ? base : sum[DW-1:0];
  endfunction
endpackage

// File: rtl/pix_testgen_frame.sv
module pix_testgen_frame
  import pixtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          line_start,
  input  logic [CW-1:0] start_len,
  input  logic [CW-1:0] valid_w,
  input  logic [CW-1:0] pitch,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] base,
  output logic          line_edge,
  output logic          started,
  output logic          in_valid,
  output logic          v_origin,
  output logic [DW-1:0] v_level
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          ls_q;
  logic [CW-1:0] pix_cnt;
  logic [CW-1:0] v_cnt;
  logic [CW-1:0] p_last;
  logic [CW:0]   valid_end;

  assign line_edge = line_start & ~ls_q;
  assign p_last    = (pitch == '0) ? '0 : pitch - 1'b1;
  assign valid_end = {1'b0, start_len} + {1'b0, valid_w};
  assign in_valid  = started && (pix_cnt >= start_len) && ({1'b0, pix_cnt} < valid_end);
  assign v_origin  = (v_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) ls_q <= 1'b0;
    else     ls_q <= line_start;
  end

  // Pixel position within the line, saturating.
  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      pix_cnt <= '0;
      started <= 1'b0;
    end else if (line_edge) begin
      pix_cnt <= '0;
      started <= 1'b1;
    end else if (started && pix_cnt != CNT_MAX) begin
      pix_cnt <= pix_cnt + 1'b1;
    end
  end

  // Line-domain pitch counter and vertical ramp level.
  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      v_cnt   <= '0;
      v_level <= base;
    end else if (line_edge) begin
      if (!started) begin
        v_cnt   <= '0;
        v_level <= base;
      end else if (v_cnt >= p_last) begin
        v_cnt   <= '0;
        v_level <= ramp_next(v_level, step, base);
      end else begin
        v_cnt <= v_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_testgen_haxis.sv
module pix_testgen_haxis
  import pixtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          adv,
  input  logic [CW-1:0] pitch,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] h_level,
  output logic          h_origin,
  output logic          h_odd
);
  logic [CW-1:0] h_cnt;
  logic [CW-1:0] p_last;

  assign p_last   = (pitch == '0) ? '0 : pitch - 1'b1;
  assign h_origin = (h_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      h_cnt   <= '0;
      h_level <= base;
      h_odd   <= 1'b0;
    end else if (adv) begin
      if (h_cnt >= p_last) begin
        h_cnt   <= '0;
        h_level <= ramp_next(h_level, step, base);
        h_odd   <= ~h_odd;
      end else begin
        h_cnt <= h_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_testgen.sv
module pix_testgen
  import pixtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_en,
  input  logic          pat_en,
  input  logic          line_start,
  input  logic [2:0]    mode,
  input  logic [CW-1:0] start_len,
  input  logic [CW-1:0] valid_w,
  input  logic [5:0]    val_hi,
  input  logic [7:0]    val_lo,
  input  logic [CW-1:0] pitch,
  input  logic [13:0]   step,
  output logic [13:0]   pix_out
);
  logic          armed;
  logic [DW-1:0] base;
  logic          line_edge, started, in_valid, v_origin;
  logic [DW-1:0] v_level, h_level;
  logic          h_origin, h_odd, h_restart;
  logic [DW-1:0] nxt;

  assign armed     = test_en & pat_en;
  assign base      = {val_hi, val_lo};
  assign h_restart = ~armed | line_edge;

  pix_testgen_frame #(.CW(CW)) u_frame (
    .clk(clk), .rst(rst), .armed(armed), .line_start(line_start),
    .start_len(start_len), .valid_w(valid_w), .pitch(pitch), .step(step),
    .base(base), .line_edge(line_edge), .started(started), .in_valid(in_valid),
    .v_origin(v_origin), .v_level(v_level)
  );

  pix_testgen_haxis #(.CW(CW)) u_haxis (
    .clk(clk), .rst(rst), .restart(h_restart), .adv(in_valid),
    .pitch(pitch), .step(step), .base(base),
    .h_level(h_level), .h_origin(h_origin), .h_odd(h_odd)
  );

  always_comb begin
    nxt = '0;
    if (armed) begin
      case (pm_e'(mode))
        PM_FIXED:     if (in_valid) nxt = base;
        PM_HRAMP:     if (in_valid) nxt = h_level;
        PM_VRAMP:     if (in_valid) nxt = v_level;
        PM_GRID:      if (in_valid) nxt = (h_origin || v_origin) ? step : base;
        PM_STRIPE:    if (in_valid) nxt = h_odd ? base : step;
        PM_WORD_SYNC: if (started)  nxt = base;
        PM_WORD_FREE: nxt = base;
        default:      nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= nxt;
  end
endmodule

// File: rtl/pix_testgen_chk.sv
module pix_testgen_chk #(
  parameter int CW = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        test_en,
  input logic        pat_en,
  input logic [2:0]  mode,
  input logic [5:0]  val_hi,
  input logic [7:0]  val_lo,
  input logic [13:0] step,
  input logic        line_edge,
  input logic        started,
  input logic        in_valid,
  input logic [13:0] pix_out
);
  logic armed;
  assign armed = test_en && pat_en;

  AST_DISARM_ZERO: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (pix_out == 14'd0)); // R1

  AST_EDGE_STARTS_LINE: assert property (@(posedge clk) disable iff (rst)
    (armed && line_edge) |=> started); // R2

  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && mode <= 3'd4 && !in_valid) |=> (pix_out == 14'd0)); // R2

  AST_FIXED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 3'd0 && in_valid) |=> (pix_out == {$past(val_hi), $past(val_lo)})); // R3

  AST_GRID_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 3'd3 && in_valid) |=>
      (pix_out == $past(step) || pix_out == {$past(val_hi), $past(val_lo)})); // R6

  AST_STRIPE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 3'd4 && in_valid) |=>
      (pix_out == $past(step) || pix_out == {$past(val_hi), $past(val_lo)})); // R7

  AST_SYNC_WAITS: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 3'd5 && !started) |=> (pix_out == 14'd0)); // R8

  AST_FREE_WORD: assert property (@(posedge clk) disable iff (rst)
    (armed && mode == 3'd6) |=> (pix_out == {$past(val_hi), $past(val_lo)})); // R9

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd7) |=> (pix_out == 14'd0)); // R10
endmodule

bind pix_testgen pix_testgen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .test_en(test_en), .pat_en(pat_en), .mode(mode),
  .val_hi(val_hi), .val_lo(val_lo), .step(step), .line_edge(line_edge),
  .started(started), .in_valid(in_valid), .pix_out(pix_out)
);

// File: tb/pix_testgen_test.sv
module pix_testgen_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst, test_en, pat_en, line_start;
  logic [2:0]  mode;
  logic [15:0] start_len, valid_w, pitch;
  logic [5:0]  val_hi;
  logic [7:0]  val_lo;
  logic [13:0] step;
  wire  [13:0] pix_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit have_exp = 0;

  // reference model state
  int    m_pc, m_line, exp_v;
  bit    m_started, m_lsp;
  string exp_tag;

  always #(CLK_PER/2) clk = ~clk;

  pix_testgen uut (
    .clk(clk), .rst(rst), .test_en(test_en), .pat_en(pat_en),
    .line_start(line_start), .mode(mode), .start_len(start_len),
    .valid_w(valid_w), .val_hi(val_hi), .val_lo(val_lo), .pitch(pitch),
    .step(step), .pix_out(pix_out)
  );

  function automatic int ramp_at(int n, int base, int inc);
    int v = base;
    for (int i = 0; i < n; i++) v = (v + inc > 16383) ? base : v + inc;
    return v;
  endfunction

  // Behavioural model: expected output after this edge, then state update.
  always @(posedge clk) begin
    int  p, h, v, s, w, e;
    bit  arm, edge_seen, valid;
    p = (pitch == 0) ? 1 : int'(pitch);
    v = int'({val_hi, val_lo});
    s = int'(start_len);
    w = int'(valid_w);
    e = int'(step);
    arm = test_en && pat_en;
    if (rst) begin
      exp_v = 0; exp_tag = "R1";
      m_started = 0; m_pc = 0; m_line = 0; m_lsp = 0;
    end else begin
      valid = m_started && m_pc >= s && m_pc < s + w;
      h = m_pc - s;
      if (!arm) begin
        exp_v = 0; exp_tag = "R1";
      end else begin
        case (mode)
          3'd5: begin exp_v = m_started ? v : 0; exp_tag = "R8"; end
          3'd6: begin exp_v = v; exp_tag = "R9"; end
          3'd7: begin exp_v = 0; exp_tag = "R10"; end
          default: begin
            if (!valid) begin
              exp_v = 0; exp_tag = "R2";
            end else begin
              case (mode)
                3'd0: begin exp_v = v; exp_tag = "R3"; end
                3'd1: begin exp_v = ramp_at(h / p, v, e); exp_tag = "R4"; end
                3'd2: begin exp_v = ramp_at(m_line / p, v, e); exp_tag = "R5"; end
                3'd3: begin
                  exp_v = (h % p == 0 || m_line % p == 0) ? e : v; exp_tag = "R6";
                end
                default: begin
                  exp_v = ((h / p) % 2 == 0) ? e : v; exp_tag = "R7";
                end
              endcase
            end
          end
        endcase
      end
      edge_seen = line_start && !m_lsp;
      m_lsp = line_start;
      if (!arm) begin
        m_started = 0; m_pc = 0; m_line = 0;
      end else if (edge_seen) begin
        m_line = m_started ? m_line + 1 : 0;
        m_started = 1; m_pc = 0;
      end else if (m_started && m_pc < 65535) begin
        m_pc = m_pc + 1;
      end
    end
    have_exp = 1;
  end

  always @(negedge clk) begin
    if (have_exp && !done) begin
      total++;
      if (int'(pix_out) != exp_v) begin
        bad++;
        $display("FAIL %s t=%0t got %h exp %h", exp_tag, $time, pix_out, exp_v);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line(int len);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic setup(int md, int sl, int wd, int pt, int value, int inc);
    mode = 3'(md); start_len = 16'(sl); valid_w = 16'(wd); pitch = 16'(pt);
    {val_hi, val_lo} = 14'(value); step = 14'(inc);
  endtask

  task automatic arm();
    test_en = 1'b1; pat_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic disarm();
    pat_en = 1'b0;
    idle(3);
  endtask

  initial begin
    rst = 1'b1; test_en = 1'b0; pat_en = 1'b0; line_start = 1'b0;
    setup(0, 0, 0, 0, 0, 0);
    idle(4);
    rst = 1'b0;
    idle(3);                                   // R1 reset and idle state
    setup(0, 3, 10, 1, 14'h0A5C, 0);           // R3 fixed value with framing (R2)
    arm(); line(20); line(20); disarm();
    setup(1, 2, 20, 2, 14'h3000, 14'h0400);    // R4 ramp wrapping at full scale
    arm(); line(30); line(30); disarm();
    setup(1, 0, 12, 0, 14'h0010, 14'h0100);    // R4 pitch 0 acts as 1
    arm(); line(16); disarm();
    setup(2, 1, 6, 2, 14'h3E00, 14'h0300);     // R5 vertical ramp with wrap
    arm(); repeat (7) line(10); disarm();
    setup(3, 2, 12, 3, 14'h3FFF, 14'h0005);    // R6 lattice
    arm(); repeat (7) line(16); disarm();
    setup(4, 1, 13, 2, 14'h1234, 14'h0777);    // R7 stripes
    arm(); line(18); line(18); disarm();
    setup(5, 4, 3, 1, 14'h2BCD, 0);            // R8 waits for edge, then continuous
    arm(); idle(5); line(12); line(12); disarm();
    setup(6, 4, 3, 1, 14'h1ACE, 0);            // R9 free running, no edge
    arm(); idle(10);
    test_en = 1'b0; idle(3);                   // R1 global enable drop alone
    test_en = 1'b1; idle(3); disarm();
    setup(7, 1, 5, 1, 14'h3333, 14'h0001);     // R10 spare code
    arm(); line(10); line(10); disarm();
    setup(4, 3, 10, 2, 14'h0F0F, 14'h00F0);    // R2 edge cuts into valid region
    arm(); line(6); line(7); line(20); disarm();
    setup(2, 0, 4, 1, 14'h0100, 14'h0100);     // R1/R5 disarm on the edge clock
    arm(); line(6); line(6);
    line_start = 1'b1; pat_en = 1'b0;
    @(negedge clk);
    line_start = 1'b0; idle(3);
    arm(); line(6); line(6);
    disarm();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R2 watchdog expired got 0 exp 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule